// File: doc/BRIEF.md
# Status Output Pin Multiplexer

This block decides, once per clock, what a dual-channel frequency synthesizer controller shows on its open-drain status pads. There are four general-purpose pads (index 0 to 3) and one shared pad that can report either general-purpose bit 0 or lock status. Every pad output is an active-high "pull low" enable. A value of 1 turns the pad's pull-down transistor on. A value of 0 releases the pad to high impedance, and an external pull-up then reads it as high.

A test-monitor control hands pads 1, 2 and 3 over to internal divider pulses: the channel A compare pulse, the channel B compare pulse and the channel B reference pulse. Pad 0 keeps its general-purpose value. A 2-bit source code picks what the shared pad reports. Two run bits, one per channel, produce the channel enables. A channel whose run bit is 0 is in power saving and is treated as unlocked wherever lock status is reported.

All pad enables and channel enables come from flip-flops. They change exactly one clock after their inputs change and carry no combinational glitches.

Top module: `smux_status_pins`

## Requirements
- R1: While rst_n is low, all pad enables (gp_pin_low_o, shared_low_o) are 0 (released) and chan_en_o is 0.
- R2: With test_mon_i = 0, gp_pin_low_o[k] is the inverse of gp_bits_i[k] for every k in 0..3. A bit value of 0 pulls the pad low and a value of 1 releases it.
- R3: Shared source code shared_sel_i = 2'b00 makes shared_low_o the inverse of gp_bits_i[0].
- R4: Code 2'b01 makes shared_low_o 0 when channel B is qualified-locked and 1 otherwise.
- R5: Code 2'b10 makes shared_low_o 0 when channel A is qualified-locked and 1 otherwise.
- R6: Code 2'b11 makes shared_low_o 0 only when both channels are qualified-locked.
- R7: With test_mon_i = 1, pads 1, 2 and 3 carry the inverse of cmp_a_i, cmp_b_i and ref_b_i respectively, and gp_bits_i[3:1] has no effect on them. Pad 0 still follows R2.
- R8: chan_en_o[0] (channel A) and chan_en_o[1] (channel B) equal run_i[0] and run_i[1]. Value 0 means power saving and value 1 means operating, and each channel is independent of the other.
- R9: A channel is qualified-locked only when both its lock input and its run bit are 1. A powered-down channel therefore reports unlocked under codes 01, 10 and 11.
- R10: Every output reflects the inputs sampled at the previous rising clock edge. Changing an input between edges leaves all outputs unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gp_bits_i | input | 4 | General-purpose pad values, 0 = pull low |
| lock_a_i | input | 1 | Lock detect, channel A |
| lock_b_i | input | 1 | Lock detect, channel B |
| shared_sel_i | input | 2 | Shared pad source code |
| test_mon_i | input | 1 | Route divider monitor pulses to pads 1..3 |
| cmp_a_i | input | 1 | Channel A compare pulse |
| cmp_b_i | input | 1 | Channel B compare pulse |
| ref_b_i | input | 1 | Channel B reference pulse |
| run_i | input | 2 | Per-channel run bits, [0] = A, [1] = B |
| gp_pin_low_o | output | 4 | Pull-low enables, pads 0..3 |
| shared_low_o | output | 1 | Pull-low enable, shared pad |
| chan_en_o | output | 2 | Channel enables, [0] = A, [1] = B |

## Verification
The block holds no state beyond one register stage. A wrong routing or qualification term therefore shows up at a pad one clock after the first input pattern that exercises it. An exhaustive sweep over every combination of the fourteen control and data inputs makes sure each term gets exercised. A missing or extra register stage shows up as outputs that move before the clock edge or one cycle late. The bench samples each output both just after an input change and one clock after it, so it catches either fault on the first vector.

// File: rtl/smux_pkg.sv
package smux_pkg;

   typedef enum logic [1:0] {
      SH_GP0       = 2'b00,
      SH_LOCK_B    = 2'b01,
      SH_LOCK_A    = 2'b10,
      SH_LOCK_BOTH = 2'b11
   } shared_src_e;

   // Logic level presented on the shared pad (1 = released/high).
   function automatic logic shared_level(input shared_src_e src,
                                         input logic gp0,
                                         input logic qlock_a,
                                         input logic qlock_b);
      logic lvl;
      unique case (src)
         SH_GP0:       lvl = gp0;
         SH_LOCK_B:    lvl = qlock_b;
         SH_LOCK_A:    lvl = qlock_a;
         SH_LOCK_BOTH: lvl = qlock_a & qlock_b;
         default:      lvl = 1'b1;
      endcase
      return lvl;
   endfunction

endpackage

// File: rtl/smux_out_stage.sv
module smux_out_stage #(
   parameter int W       = 1,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("smux_out_stage: W must be at least 1");
   end

   if (OUT_REG) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= '0;
         else        q_r <= d_i;
      end
      assign q_o = q_r;
   end else begin : g_thru
      assign q_o = d_i;
   end

endmodule

// File: rtl/smux_chan_gate.sv
module smux_chan_gate #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic lock_i,
   output logic qlock_o,
   output logic en_o
);

   // A channel in power saving never counts as locked.
   assign qlock_o = lock_i & run_i;

   smux_out_stage #(.W(1), .OUT_REG(OUT_REG)) u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (run_i),
      .q_o   (en_o)
   );

   if (OUT_REG) begin : g_chk
      p_en_follows_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (en_o == $past(run_i)))
         else $error("R8 channel enable does not follow run bit");
      p_off_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !run_i |-> !qlock_o)
         else $error("R9 powered-down channel reported locked");
   end

endmodule

// File: rtl/smux_gp_route.sv
module smux_gp_route #(
   parameter int GP_W  = 4,
   parameter int MON_W = 3
) (
   input  logic [GP_W-1:0]  gp_i,
   input  logic [MON_W-1:0] mon_i,
   input  logic             test_i,
   output logic [GP_W-1:0]  level_o
);

   if (GP_W != MON_W + 1) begin : g_bad_w
      $error("smux_gp_route: GP_W must equal MON_W + 1");
   end

   for (genvar k = 0; k < GP_W; k++) begin : g_pin
      if (k >= 1 && k <= MON_W) begin : g_mon
         assign level_o[k] = test_i ? mon_i[k-1] : gp_i[k];
      end else begin : g_plain
         assign level_o[k] = gp_i[k];
      end
   end

endmodule

// File: rtl/smux_status_pins.sv
module smux_status_pins #(
   parameter int GP_W    = 4,
   parameter int MON_W   = 3,
   parameter int N_CH    = 2,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       gp_bits_i,
   input  logic             lock_a_i,
   input  logic             lock_b_i,
   input  logic [1:0]       shared_sel_i,
   input  logic             test_mon_i,
   input  logic             cmp_a_i,
   input  logic             cmp_b_i,
   input  logic             ref_b_i,
   input  logic [1:0]       run_i,
   output logic [3:0]       gp_pin_low_o,
   output logic             shared_low_o,
   output logic [1:0]       chan_en_o
);
   import smux_pkg::*;

   localparam int OUT_W = GP_W + 1;

   if (GP_W != 4 || MON_W != 3 || N_CH != 2) begin : g_bad_cfg
      $error("smux_status_pins: port widths fix GP_W=4, MON_W=3, N_CH=2");
   end

   logic [N_CH-1:0]  lock_vec;
   logic [N_CH-1:0]  qlock;
   logic [MON_W-1:0] mon_vec;
   logic [GP_W-1:0]  pad_level;
   logic             sh_level;
   logic [OUT_W-1:0] low_d;
   logic [OUT_W-1:0] low_q;

   assign lock_vec = {lock_b_i, lock_a_i};
   assign mon_vec  = {ref_b_i, cmp_b_i, cmp_a_i};

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      smux_chan_gate #(.OUT_REG(OUT_REG)) u_gate (
         .clk     (clk),
         .rst_n   (rst_n),
         .run_i   (run_i[c]),
         .lock_i  (lock_vec[c]),
         .qlock_o (qlock[c]),
         .en_o    (chan_en_o[c])
      );
   end

   smux_gp_route #(.GP_W(GP_W), .MON_W(MON_W)) u_route (
      .gp_i    (gp_bits_i),
      .mon_i   (mon_vec),
      .test_i  (test_mon_i),
      .level_o (pad_level)
   );

   assign sh_level = shared_level(shared_src_e'(shared_sel_i), gp_bits_i[0],
                                  qlock[0], qlock[1]);

   // Open drain: a low level means the pull-down is enabled.
   assign low_d = ~{sh_level, pad_level};

   smux_out_stage #(.W(OUT_W), .OUT_REG(OUT_REG)) u_pads (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (low_d),
      .q_o   (low_q)
   );

   assign gp_pin_low_o = low_q[GP_W-1:0];
   assign shared_low_o = low_q[GP_W];

   if (OUT_REG) begin : g_chk
      p_pad0_gp_r2: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (gp_pin_low_o[0] == !$past(gp_bits_i[0])))
         else $error("R2 pad 0 mismatch");
      p_shared_gp0_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (shared_sel_i == 2'b00) |=> (shared_low_o == !$past(gp_bits_i[0])))
         else $error("R3 shared pad mismatch");
      p_shared_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (shared_sel_i == 2'b11) |=>
            (shared_low_o == !($past(lock_a_i & run_i[0]) && $past(lock_b_i & run_i[1]))))
         else $error("R6 shared pad combined lock mismatch");
      p_pad1_mon_r7: assert property (@(posedge clk) disable iff (!rst_n)
         test_mon_i |=> (gp_pin_low_o[1] == !$past(cmp_a_i)))
         else $error("R7 pad 1 monitor mismatch");
      p_pad3_mon_r7: assert property (@(posedge clk) disable iff (!rst_n)
         test_mon_i |=> (gp_pin_low_o[3] == !$past(ref_b_i)))
         else $error("R7 pad 3 monitor mismatch");
   end

endmodule

// File: tb/tb_smux_status_pins.sv
`timescale 1ns/1ps
module tb_smux_status_pins;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] gp_bits_i;
   logic       lock_a_i, lock_b_i;
   logic [1:0] shared_sel_i;
   logic       test_mon_i, cmp_a_i, cmp_b_i, ref_b_i;
   logic [1:0] run_i;
   logic [3:0] gp_pin_low_o;
   logic       shared_low_o;
   logic [1:0] chan_en_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   smux_status_pins dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .gp_bits_i    (gp_bits_i),
      .lock_a_i     (lock_a_i),
      .lock_b_i     (lock_b_i),
      .shared_sel_i (shared_sel_i),
      .test_mon_i   (test_mon_i),
      .cmp_a_i      (cmp_a_i),
      .cmp_b_i      (cmp_b_i),
      .ref_b_i      (ref_b_i),
      .run_i        (run_i),
      .gp_pin_low_o (gp_pin_low_o),
      .shared_low_o (shared_low_o),
      .chan_en_o    (chan_en_o)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [6:0] expect_out(input logic [13:0] v);
      logic [3:0] gp;
      logic la, lb, tst, ca, cb, rb, qa, qb, sh;
      logic [1:0] sel, run;
      logic [3:0] lvl;
      gp  = v[3:0];   la  = v[4];   lb = v[5];  sel = v[7:6];
      tst = v[8];     ca  = v[9];   cb = v[10]; rb  = v[11];
      run = v[13:12];
      qa = la & run[0];
      qb = lb & run[1];
      case (sel)
         2'b00: sh = gp[0];
         2'b01: sh = qb;
         2'b10: sh = qa;
         default: sh = qa & qb;
      endcase
      lvl = tst ? {rb, cb, ca, gp[0]} : gp;
      return {run, ~sh, ~lvl};
   endfunction

   task automatic apply(input logic [13:0] v);
      gp_bits_i    = v[3:0];
      lock_a_i     = v[4];
      lock_b_i     = v[5];
      shared_sel_i = v[7:6];
      test_mon_i   = v[8];
      cmp_a_i      = v[9];
      cmp_b_i      = v[10];
      ref_b_i      = v[11];
      run_i        = v[13:12];
   endtask

   initial begin
      logic [6:0]  prev_exp;
      logic [6:0]  e;
      logic [13:0] prev_v;
      rst_n = 1'b1;
      apply(14'h3FFF);
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 pads", {4'b0, gp_pin_low_o}, 8'h00);
      check("R1 shared", {7'b0, shared_low_o}, 8'h00);
      check("R1 chan_en", {6'b0, chan_en_o}, 8'h00);
      rst_n = 1'b1;
      prev_exp = 7'h00;
      prev_v   = 14'h3FFF;
      for (int v = 0; v < 16384; v++) begin
         apply(v[13:0]);
         #1;
         // R10: nothing moves before the next edge
         check("R10 hold", {1'b0, chan_en_o, shared_low_o, gp_pin_low_o}, {1'b0, prev_exp});
         @(negedge clk);
         e = expect_out(v[13:0]);
         if (v[8]) check("R7 pads", {4'b0, gp_pin_low_o}, {4'b0, e[3:0]});
         else      check("R2 pads", {4'b0, gp_pin_low_o}, {4'b0, e[3:0]});
         if (v[7:6] == 2'b00)                     check("R3 shared", {7'b0, shared_low_o}, {7'b0, e[4]});
         else if (v[13:12] != 2'b11)              check("R9 shared", {7'b0, shared_low_o}, {7'b0, e[4]});
         else if (v[7:6] == 2'b01)                check("R4 shared", {7'b0, shared_low_o}, {7'b0, e[4]});
         else if (v[7:6] == 2'b10)                check("R5 shared", {7'b0, shared_low_o}, {7'b0, e[4]});
         else                                     check("R6 shared", {7'b0, shared_low_o}, {7'b0, e[4]});
         check("R8 chan_en", {6'b0, chan_en_o}, {6'b0, e[6:5]});
         prev_exp = e;
         prev_v   = v[13:0];
      end
      if (prev_v != 14'h3FFF) check("R10 sweep end", 8'h00, 8'h00);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule